// File: doc/BRIEF.md
# Polar Belief-Propagation Butterfly Processing Element

This block carries out the arithmetic of belief-propagation decoding for polar codes across a group of `K` butterflies in a single cycle. Each butterfly takes four signed 8-bit soft messages. Two of them are the left-going messages from the right-hand column of the factor graph. The other two are the right-going messages from the left-hand column. From these the block computes either the two new left-going messages or the two new right-going messages. Both directions run on one shared datapath built from a scaled min-sum kernel. Every addition and negation grows a guard bit before the result is clamped back to 8 bits.

A third mode turns the same lanes into final-decision logic. In this mode each node's bit is the sign of its left message plus its right message. Inputs are sampled when `validIn` is high, and the results show up on registered outputs one cycle later, together with `validOut`. Memory, permutation of messages between lanes and scheduling of stages all sit outside the block.

Top module: `polar_bp_pe`

## Requirements
- R1: While `rstN` is low, `validOut`, every byte of `msgOut` and every bit of `hardOut` are zero.
- R2: `validOut` is high in exactly the cycle after a cycle in which `validIn` was high. The results for that sample are on the outputs in that same cycle.
- R3: The kernel is g(x,y) = sgn(x)·sgn(y)·min(|x|,|y|), with a zero operand giving 0. It is then scaled as v + floor(−v/16), which is close to 15/16 of v.
- R4: Butterfly k takes the bytes `msgIn[32k +: 32]` in this order from low byte to high byte: A (upper left message), B (lower left message), C (upper right message), D (lower right message). With `mode` = 2'b00 (leftward update), the low output byte is g(A, B+D) and the high output byte is g(C, A)+B. Butterfly k writes to `msgOut[16k +: 16]`.
- R5: With `mode` = 2'b01 (rightward update), the low output byte is g(C, B+D) and the high output byte is g(C, A)+D.
- R6: Every message output is clamped to the 8-bit range. A result above 127 becomes 127, and a result below −128 becomes −128.
- R7: With `mode[1]` = 1 (decision mode, `mode[0]` ignored), `hardOut[2k]` is 1 exactly when A+C < 0, and `hardOut[2k+1]` is 1 exactly when B+D < 0. The sums are taken at full width.
- R8: A cycle with `validIn` low leaves `msgOut` and `hardOut` unchanged.
- R9: A decision-mode sample leaves `msgOut` unchanged, and a message-mode sample leaves `hardOut` unchanged.
- R10: The `K` butterflies are independent. Each lane's outputs depend only on that lane's four input bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Sample inputs this cycle |
| mode | input | 2 | 00 leftward, 01 rightward, 1x hard decision |
| msgIn | input | 32*K | Four 8-bit messages per butterfly |
| validOut | output | 1 | Results registered from the previous cycle |
| msgOut | output | 16*K | Two updated 8-bit messages per butterfly |
| hardOut | output | 2*K | Two decided bits per butterfly |

## Verification
Every result (both message bytes, both decision bits and `validOut`) passes through exactly one register. It is therefore due at the first rising edge after the sampling edge. The bench drives inputs on the falling edge and compares all outputs on the following falling edge against a reference model. That model is advanced only on valid samples, by result class, so the hold behaviour and the mode isolation are checked in the same cycle as the arithmetic.

// File: rtl/polar_bp_pkg.sv
package polar_bp_pkg;
  localparam int MSG_W  = 8;
  localparam int SUM_W  = MSG_W + 1;
  localparam int WIDE_W = MSG_W + 2;

  typedef enum logic [1:0] {
    MODE_LEFT  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_HARD  = 2'b10
  } modeT;

  typedef struct packed {
    logic capMsg;
    logic capHard;
    logic dirRight;
  } strobeT;

  // scaled min-sum kernel on guard-extended operands
  function automatic logic signed [WIDE_W-1:0] scaledMin(
      input logic signed [WIDE_W-1:0] x,
      input logic signed [WIDE_W-1:0] y);
    logic signed [WIDE_W-1:0] negX, negY, pick, negPick;
    logic xGeY, xGeNegY;
    negX    = -x;
    negY    = -y;
    xGeY    = (x >= y);
    xGeNegY = (x >= negY);
    case ({xGeY, xGeNegY})
      2'b11:   pick = y;
      2'b10:   pick = negX;
      2'b01:   pick = x;
      default: pick = negY;
    endcase
    negPick = -pick;
    return pick + (negPick >>> 4);
  endfunction

  function automatic logic signed [MSG_W-1:0] clampMsg(
      input logic signed [WIDE_W-1:0] v);
    logic signed [MSG_W-1:0] res;
    if (v[WIDE_W-1:MSG_W-1] == '0 || v[WIDE_W-1:MSG_W-1] == '1)
      res = v[MSG_W-1:0];
    else if (v[WIDE_W-1])
      res = {1'b1, {(MSG_W-1){1'b0}}};
    else
      res = {1'b0, {(MSG_W-1){1'b1}}};
    return res;
  endfunction
endpackage

// File: rtl/polar_bp_ctrl.sv
module polar_bp_ctrl
  import polar_bp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       validIn,
  input  logic [1:0] mode,
  output strobeT     strobe,
  output logic       validOut
);
  always_comb begin
    strobe.capMsg   = validIn & ~mode[1];
    strobe.capHard  = validIn &  mode[1];
    strobe.dirRight = mode[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= validIn;
  end
endmodule

// File: rtl/polar_bp_bfly.sv
module polar_bp_bfly
  import polar_bp_pkg::*;
(
  input  logic signed [MSG_W-1:0] msgA,
  input  logic signed [MSG_W-1:0] msgB,
  input  logic signed [MSG_W-1:0] msgC,
  input  logic signed [MSG_W-1:0] msgD,
  input  logic                    dirRight,
  output logic signed [MSG_W-1:0] outLo,
  output logic signed [MSG_W-1:0] outHi,
  output logic                    hardAC,
  output logic                    hardBD
);
  logic signed [SUM_W-1:0]  sumBD, sumAC;
  logic signed [WIDE_W-1:0] xLo, fLo, fCA, addend, sumHi;

  always_comb begin
    sumBD  = SUM_W'(msgB) + SUM_W'(msgD);
    sumAC  = SUM_W'(msgA) + SUM_W'(msgC);
    xLo    = dirRight ? WIDE_W'(msgC) : WIDE_W'(msgA);
    fLo    = scaledMin(xLo, WIDE_W'(sumBD));
    fCA    = scaledMin(WIDE_W'(msgC), WIDE_W'(msgA));
    addend = dirRight ? WIDE_W'(msgD) : WIDE_W'(msgB);
    sumHi  = fCA + addend;
    outLo  = clampMsg(fLo);
    outHi  = clampMsg(sumHi);
    hardAC = sumAC[SUM_W-1];
    hardBD = sumBD[SUM_W-1];
  end
endmodule

// File: rtl/polar_bp_datapath.sv
module polar_bp_datapath
  import polar_bp_pkg::*;
#(
  parameter int K = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  strobeT                 strobe,
  input  logic [K*4*MSG_W-1:0]   msgIn,
  output logic [K*2*MSG_W-1:0]   msgOut,
  output logic [K*2-1:0]         hardOut
);
  localparam int IN_LANE  = 4 * MSG_W;
  localparam int OUT_LANE = 2 * MSG_W;

  logic [K*2*MSG_W-1:0] msgNext;
  logic [K*2-1:0]       hardNext;

  for (genvar k = 0; k < K; k++) begin : g_lane
    logic [IN_LANE-1:0] laneIn;
    logic signed [MSG_W-1:0] lo, hi;
    logic hAC, hBD;
    assign laneIn = msgIn[k*IN_LANE +: IN_LANE];
    polar_bp_bfly bfly_i (
      .msgA    (laneIn[0*MSG_W +: MSG_W]),
      .msgB    (laneIn[1*MSG_W +: MSG_W]),
      .msgC    (laneIn[2*MSG_W +: MSG_W]),
      .msgD    (laneIn[3*MSG_W +: MSG_W]),
      .dirRight(strobe.dirRight),
      .outLo   (lo),
      .outHi   (hi),
      .hardAC  (hAC),
      .hardBD  (hBD)
    );
    assign msgNext[k*OUT_LANE +: OUT_LANE] = {hi, lo};
    assign hardNext[2*k +: 2]              = {hBD, hAC};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgOut  <= '0;
      hardOut <= '0;
    end else begin
      if (strobe.capMsg)  msgOut  <= msgNext;
      if (strobe.capHard) hardOut <= hardNext;
    end
  end
endmodule

// File: rtl/polar_bp_pe.sv
module polar_bp_pe
  import polar_bp_pkg::*;
#(
  parameter int K = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               validIn,
  input  logic [1:0]         mode,
  input  logic [K*32-1:0]    msgIn,
  output logic               validOut,
  output logic [K*16-1:0]    msgOut,
  output logic [K*2-1:0]     hardOut
);
  strobeT strobe;

  polar_bp_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .validIn (validIn),
    .mode    (mode),
    .strobe  (strobe),
    .validOut(validOut)
  );

  polar_bp_datapath #(.K(K)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .msgIn  (msgIn),
    .msgOut (msgOut),
    .hardOut(hardOut)
  );
endmodule

// File: rtl/polar_bp_pe_chk.sv
module polar_bp_pe_chk #(
  parameter int K = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            validIn,
  input logic [1:0]      mode,
  input logic [K*32-1:0] msgIn,
  input logic            validOut,
  input logic [K*16-1:0] msgOut,
  input logic [K*2-1:0]  hardOut
);
  logic [8:0] lane0AC;
  assign lane0AC = {msgIn[7], msgIn[7:0]} + {msgIn[23], msgIn[23:16]};

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);
  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(msgOut) && $stable(hardOut)));
  a_r9_hard_keeps_msg: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && mode[1]) |=> $stable(msgOut));
  a_r9_msg_keeps_hard: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && !mode[1]) |=> $stable(hardOut));
  a_r7_lane0_sign: assert property (@(posedge clk) disable iff (!rstN)
    (validIn && mode[1]) |=> (hardOut[0] == $past(lane0AC[8])));
endmodule

bind polar_bp_pe polar_bp_pe_chk #(.K(K)) chk_i (
  .clk(clk), .rstN(rstN), .validIn(validIn), .mode(mode), .msgIn(msgIn),
  .validOut(validOut), .msgOut(msgOut), .hardOut(hardOut)
);

// File: tb/polar_bp_pe_tb_top.sv
`timescale 1ns/1ps
module polar_bp_pe_tb_top;
  localparam int K = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            validIn = 1'b0;
  logic [1:0]      mode = 2'b00;
  logic [K*32-1:0] msgIn = '0;
  logic            validOut;
  logic [K*16-1:0] msgOut;
  logic [K*2-1:0]  hardOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [K*16-1:0] expMsg = '0;
  logic [K*2-1:0]  expHard = '0;

  always #10 clk = ~clk;

  polar_bp_pe #(.K(K)) dut_i (
    .clk(clk), .rstN(rstN), .validIn(validIn), .mode(mode), .msgIn(msgIn),
    .validOut(validOut), .msgOut(msgOut), .hardOut(hardOut)
  );

  function automatic int kern(int x, int y);
    int ax = (x < 0) ? -x : x;
    int ay = (y < 0) ? -y : y;
    int m  = (ax < ay) ? ax : ay;
    int v  = (((x < 0) != (y < 0)) ? -m : m);
    return v + ((-v) >>> 4);
  endfunction

  function automatic int clampV(int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic int sb(logic [7:0] b);
    return int'($signed(b));
  endfunction

  task automatic check(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // advance model on one sample (R4, R5, R7, R9)
  task automatic model(logic [1:0] md, logic [K*32-1:0] vec);
    for (int k = 0; k < K; k++) begin
      int a = sb(vec[k*32 +: 8]);
      int b = sb(vec[k*32+8 +: 8]);
      int c = sb(vec[k*32+16 +: 8]);
      int d = sb(vec[k*32+24 +: 8]);
      int lo, hi;
      if (md[1]) begin
        expHard[2*k]   = (a + c) < 0;
        expHard[2*k+1] = (b + d) < 0;
      end else begin
        if (md[0]) begin
          lo = clampV(kern(c, b + d));
          hi = clampV(kern(c, a) + d);
        end else begin
          lo = clampV(kern(a, b + d));
          hi = clampV(kern(c, a) + b);
        end
        expMsg[k*16 +: 8]   = 8'(lo);
        expMsg[k*16+8 +: 8] = 8'(hi);
      end
    end
  endtask

  task automatic step(logic v, logic [1:0] md, logic [K*32-1:0] vec, string req);
    @(negedge clk);
    validIn = v; mode = md; msgIn = vec;
    if (v) model(md, vec);
    @(negedge clk);
    check({req, " R2 validOut"}, 256'(validOut), 256'(v));
    check({req, " msgOut"}, 256'(msgOut), 256'(expMsg));
    check({req, " hardOut"}, 256'(hardOut), 256'(expHard));
    validIn = 1'b0;
  endtask

  function automatic logic [K*32-1:0] fill(logic [31:0] lane);
    logic [K*32-1:0] r;
    for (int k = 0; k < K; k++) r[k*32 +: 32] = lane;
    return r;
  endfunction

  initial begin
    logic [K*32-1:0] vec;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 validOut", 256'(validOut), 256'(0));
    check("R1 msgOut", 256'(msgOut), 256'(0));
    check("R1 hardOut", 256'(hardOut), 256'(0));
    rstN = 1'b1;
    // R6 positive clamp: g(127,127)=119, +127 -> 127 (left mode, D=A=C=B=127)
    step(1'b1, 2'b00, fill(32'h7F7F7F7F), "R6 R4 pos clamp");
    // R6 negative clamp: C=127, A=-128, B=-128 -> -120-128
    step(1'b1, 2'b00, fill({8'h00, 8'h7F, 8'h80, 8'h80}), "R6 neg clamp");
    // R3 kernel at extremes, right mode: C=-128, B=D=-128 -> 120
    step(1'b1, 2'b01, fill(32'h80808080), "R3 R5 extreme");
    // R3 zero operand
    step(1'b1, 2'b01, fill({8'h05, 8'h00, 8'hFB, 8'h09}), "R3 zero");
    // R8 idle with garbage input
    step(1'b0, 2'b00, fill(32'hDEADBEEF), "R8 idle");
    // R7 decision, mode 11 same as 10; R9 msgOut kept
    step(1'b1, 2'b11, fill({8'h01, 8'hFF, 8'h00, 8'hFF}), "R7 R9 hard");
    step(1'b1, 2'b10, fill({8'h80, 8'h7F, 8'h7F, 8'h80}), "R7 sum edge");
    // R10 lanes differ
    vec = '0;
    for (int k = 0; k < K; k++) vec[k*32 +: 32] = {8'(k*40), 8'(-k*20), 8'(k*7), 8'(100-k*60)};
    step(1'b1, 2'b00, vec, "R10 R4 lanes");
    step(1'b1, 2'b01, vec, "R10 R5 lanes");
    // R2 back-to-back plus random mix
    for (int i = 0; i < 400; i++) begin
      logic [K*32-1:0] rv;
      for (int k = 0; k < K; k++) rv[k*32 +: 32] = $urandom;
      step(($urandom % 4) != 0, 2'($urandom), rv, "R3 R4 R5 R7 R8 R9 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule